// File: doc/BRIEF.md
# Streaming CRC-32 Appender

This block sits in a 32-bit AXI4-Stream path and passes every payload word through unchanged. While the words pass, it folds them into a 32-bit CRC. When the word flagged as last has been taken in, the block adds one trailing beat to the packet. That beat carries the finished checksum and is the only beat with TLAST set, so a receiver sees the original payload with its CRC appended.

The generator polynomial, the seed, the final XOR mask and the two reflection switches are plain input pins. They are captured on the first accepted beat of each packet and held until that packet is complete. One block can therefore serve several CRC-32 flavours, changing from one packet to the next. Backpressure is honoured on both sides. A new packet may start on the same edge that the previous checksum beat is consumed.

Top module: `crc_stream_appender`

## Requirements
- R1: Each accepted input word appears on the master port unchanged and in arrival order, with m_last_o low on every payload beat, including the beat that arrived with s_last_i high.
- R2: After the input beat with s_last_i high is accepted, exactly one further beat is emitted before any word of the next packet; its data is the finished CRC and m_last_o is high on it.
- R3: The CRC processes each word as four bytes, least significant byte (bits 7:0) first, and each byte most significant bit first. The shift register starts from the seed and XORs in the polynomial whenever the bit shifted out differs from the message bit. With polynomial 0x04C11DB7, seed 0, mask 0 and refl_i = 2'b00, the words 0x6C6C6548, 0x6F57206F, 0x21646C72 give 0x9D79D770.
- R4: refl_i[0] reverses the bit order within each input byte, and refl_i[1] bit-reverses the 32-bit register before the final XOR. With the R3 setup and refl_i = 2'b11, the result is 0x67FCDACC.
- R5: The final XOR mask is applied to the (possibly reflected) register. With polynomial 0x04C11DB7, seed 0xFFFFFFFF, mask 0xFFFFFFFF and the R3 words, the result is 0x1C291CA3 for refl_i = 2'b11 and 0x6B1A7CAE for refl_i = 2'b00.
- R6: All configuration inputs are sampled on the first accepted beat of a packet. Changes to them during the rest of the packet have no effect on that packet's CRC.
- R7: s_ready_o is low from the cycle after the last input beat is accepted until the CRC beat has been loaded onto the master port. No input beat is accepted while a CRC beat is still owed.
- R8: While m_valid_o is high and m_ready_i is low, m_valid_o, m_data_o and m_last_o hold their values. No beat is lost or duplicated under any pattern of m_ready_i or s_valid_i.
- R9: When the CRC beat is consumed, s_ready_o is high in that same cycle, so the first word of the next packet can be accepted on that edge.
- R10: During reset m_valid_o is low and s_ready_o is high. A packet may be a single beat long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poly_i | input | 32 | Generator polynomial, normal (non-reversed) form |
| init_i | input | 32 | Seed loaded at packet start |
| xor_out_i | input | 32 | Mask XORed onto the finished CRC |
| refl_i | input | 2 | Bit 0: reflect input bytes; bit 1: reflect output CRC |
| s_valid_i | input | 1 | Slave-side beat valid |
| s_data_i | input | 32 | Slave-side payload word |
| s_last_i | input | 1 | Slave-side last word of packet |
| s_ready_o | output | 1 | Slave-side ready |
| m_valid_o | output | 1 | Master-side beat valid |
| m_data_o | output | 32 | Master-side payload word or CRC |
| m_last_o | output | 1 | High on the appended CRC beat only |
| m_ready_i | input | 1 | Master-side ready |

## Verification
Two functions can fall in the same cycle: the hand-off of one packet's CRC beat to the consumer, and the acceptance of the next packet's first word, which also reloads the CRC register and the captured configuration. The bench drives two packets back to back with the consumer always ready and with a different configuration on each. It records the edge on which the CRC beat is consumed and the edge on which the next first word is accepted, and requires them to be the same. The reference model must still predict both checksums, which shows that the reload did not corrupt the outgoing CRC. Random backpressure on both sides also produces cases where the CRC beat stalls while a new word is waiting; there the model requires that no input is accepted early.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;
  parameter int unsigned CRC_W  = 32;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    crc_t poly;
    crc_t init;
    crc_t xor_out;
    logic refl_out;
    logic refl_in;
  } crc_cfg_t;

  function automatic byte_t rev_byte(input byte_t b);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  function automatic crc_t rev_crc(input crc_t c);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = c[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_app_byte_step.sv
module crc_app_byte_step
  import crc_app_pkg::*;
(
  input  crc_t  crc_i,
  input  byte_t byte_i,
  input  crc_t  poly_i,
  input  logic  refl_i,
  output crc_t  crc_o
);
  byte_t b_eff;
  crc_t  c;

  always_comb begin
    b_eff = refl_i ? rev_byte(byte_i) : byte_i;
    c = crc_i ^ {b_eff, {(CRC_W-BYTE_W){1'b0}}};
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[CRC_W-1] ? ({c[CRC_W-2:0], 1'b0} ^ poly_i) : {c[CRC_W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/crc_app_word_step.sv
module crc_app_word_step
  import crc_app_pkg::*;
(
  input  crc_t  crc_i,
  input  word_t data_i,
  input  crc_t  poly_i,
  input  logic  refl_i,
  output crc_t  crc_o
);
  crc_t chain [NBYTES+1];

  assign chain[0] = crc_i;

  // low byte first
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    crc_app_byte_step u_step (
      .crc_i  (chain[gb]),
      .byte_i (data_i[gb*BYTE_W +: BYTE_W]),
      .poly_i (poly_i),
      .refl_i (refl_i),
      .crc_o  (chain[gb+1])
    );
  end

  assign crc_o = chain[NBYTES];
endmodule

// File: rtl/crc_app_accum.sv
module crc_app_accum
  import crc_app_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     accept_i,
  input  logic     last_i,
  input  word_t    data_i,
  input  crc_cfg_t cfg_i,
  output crc_t     crc_final_o
);
  logic     first_q;
  crc_cfg_t cfg_q, cfg_use;
  crc_t     crc_q, crc_base, crc_next, crc_refl;

  // first beat bypasses the captured config
  assign cfg_use  = first_q ? cfg_i : cfg_q;
  assign crc_base = first_q ? cfg_i.init : crc_q;

  crc_app_word_step u_word (
    .crc_i  (crc_base),
    .data_i (data_i),
    .poly_i (cfg_use.poly),
    .refl_i (cfg_use.refl_in),
    .crc_o  (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      cfg_q   <= '0;
      crc_q   <= '0;
    end else if (accept_i) begin
      crc_q   <= crc_next;
      first_q <= last_i;
      if (first_q) cfg_q <= cfg_i;
    end
  end

  assign crc_refl    = cfg_q.refl_out ? rev_crc(crc_q) : crc_q;
  assign crc_final_o = crc_refl ^ cfg_q.xor_out;

  // R6
  // cfg_hold_chk
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_q) |=> $stable(cfg_q));
endmodule

// File: rtl/crc_app_out_stage.sv
module crc_app_out_stage
  import crc_app_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_pay_i,
  input  word_t pay_data_i,
  input  logic  load_crc_i,
  input  crc_t  crc_data_i,
  input  logic  m_ready_i,
  output logic  can_take_o,
  output logic  m_valid_o,
  output word_t m_data_o,
  output logic  m_last_o
);
  logic  valid_q, last_q;
  word_t data_q;

  assign can_take_o = !valid_q || m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
    end else if (load_pay_i) begin
      valid_q <= 1'b1;
      last_q  <= 1'b0;
      data_q  <= pay_data_i;
    end else if (load_crc_i) begin
      valid_q <= 1'b1;
      last_q  <= 1'b1;
      data_q  <= word_t'(crc_data_i);
    end else if (m_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign m_valid_o = valid_q;
  assign m_data_o  = data_q;
  assign m_last_o  = last_q;

  // R8
  // out_hold_chk
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !m_ready_i) |=> (valid_q && $stable(data_q) && $stable(last_q)));
endmodule

// File: rtl/crc_stream_appender.sv
module crc_stream_appender
  import crc_app_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] poly_i,
  input  logic [31:0] init_i,
  input  logic [31:0] xor_out_i,
  input  logic [1:0]  refl_i,
  input  logic        s_valid_i,
  input  logic [31:0] s_data_i,
  input  logic        s_last_i,
  output logic        s_ready_o,
  output logic        m_valid_o,
  output logic [31:0] m_data_o,
  output logic        m_last_o,
  input  logic        m_ready_i
);
  crc_cfg_t cfg;
  crc_t     crc_final;
  logic     pending_q, can_take, accept, load_crc;

  assign cfg = '{poly: poly_i, init: init_i, xor_out: xor_out_i,
                 refl_out: refl_i[1], refl_in: refl_i[0]};

  assign s_ready_o = can_take && !pending_q;
  assign accept    = s_valid_i && s_ready_o;
  assign load_crc  = pending_q && can_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pending_q <= 1'b0;
    else if (accept && s_last_i) pending_q <= 1'b1;
    else if (load_crc)           pending_q <= 1'b0;
  end

  crc_app_accum u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .last_i      (s_last_i),
    .data_i      (s_data_i),
    .cfg_i       (cfg),
    .crc_final_o (crc_final)
  );

  crc_app_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_pay_i (accept),
    .pay_data_i (s_data_i),
    .load_crc_i (load_crc),
    .crc_data_i (crc_final),
    .m_ready_i  (m_ready_i),
    .can_take_o (can_take),
    .m_valid_o  (m_valid_o),
    .m_data_o   (m_data_o),
    .m_last_o   (m_last_o)
  );

  // R1
  // pay_pass_chk
  pay_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (m_valid_o && !m_last_o && m_data_o == $past(s_data_i)));

  // R2
  // crc_beat_chk
  crc_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && (!m_valid_o || m_ready_i)) |=> (m_valid_o && m_last_o));

  // R7
  // stall_after_last_chk
  stall_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && s_last_i) |=> !s_ready_o);

  // R9
  // b2b_ready_chk
  b2b_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_last_o && m_ready_i) |-> s_ready_o);
endmodule

// File: tb/crc_stream_appender_tb_top.sv
module crc_stream_appender_tb_top;
  localparam int CLK_PERIOD_NS = 10;
  localparam int WATCHDOG_CYC  = 150000;

  typedef struct {
    logic [31:0] data;
    logic        last;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] poly_i = 32'h04C11DB7, init_i = '0, xor_out_i = '0;
  logic [1:0]  refl_i = 2'b00;
  logic        s_valid_i = 1'b0, s_last_i = 1'b0, m_ready_i = 1'b1;
  logic [31:0] s_data_i = '0;
  logic        s_ready_o, m_valid_o, m_last_o;
  logic [31:0] m_data_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, rdy_rand = 0;

  beat_t       exp_q[$];
  int          crc_owed = 0;
  bit          mdl_first = 1;
  logic [31:0] mdl_crc, mdl_poly, mdl_xo;
  bit          mdl_ri, mdl_ro;
  logic [31:0] last_crc_seen = '0;
  int          last_crc_edge = -100, gap_to_crc = -1;
  bit          prev_hold = 0;
  logic [31:0] prev_data;
  logic        prev_last;

  crc_stream_appender dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .poly_i(poly_i), .init_i(init_i),
    .xor_out_i(xor_out_i), .refl_i(refl_i), .s_valid_i(s_valid_i),
    .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_last_o(m_last_o),
    .m_ready_i(m_ready_i)
  );

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_step(input logic [31:0] c, input logic [31:0] w,
                                           input logic [31:0] p, input bit ri);
    for (int by = 0; by < 4; by++)
      for (int k = 0; k < 8; k++) begin
        logic b, fb;
        b  = ri ? w[by*8 + k] : w[by*8 + 7 - k];
        fb = c[31] ^ b;
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ p;
      end
    return c;
  endfunction

  function automatic logic [31:0] mdl_final(input logic [31:0] c, input bit ro, input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = ro ? c[31-i] : c[i];
    return r ^ x;
  endfunction

  // monitor: values seen at negedge are the ones the next posedge acts on
  always @(negedge clk) begin
    cyc++;
    if (!rst_ni) begin
      prev_hold = 0;
    end else begin
      if (prev_hold) begin
        // R8
        check(m_valid_o == 1'b1, "R8 valid held", {31'b0, m_valid_o}, 32'd1);
        check(m_data_o == prev_data && m_last_o == prev_last, "R8 data held", m_data_o, prev_data);
      end
      prev_hold = m_valid_o && !m_ready_i;
      prev_data = m_data_o;
      prev_last = m_last_o;

      if (m_valid_o && m_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected beat", m_data_o, 32'hX);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          // R1 payload, R2 trailing CRC beat
          check(m_data_o == e.data, e.last ? "R2 crc data" : "R1 payload data", m_data_o, e.data);
          check(m_last_o == e.last, "R1 R2 last flag", {31'b0, m_last_o}, {31'b0, e.last});
          if (e.last) begin
            crc_owed--;
            last_crc_seen = m_data_o;
            last_crc_edge = cyc;
          end
        end
      end

      if (s_valid_i && s_ready_o) begin
        // R7
        check(crc_owed == 0, "R7 accept while crc owed", crc_owed, 0);
        if (mdl_first) begin
          mdl_crc  = init_i;
          mdl_poly = poly_i;
          mdl_xo   = xor_out_i;
          mdl_ri   = refl_i[0];
          mdl_ro   = refl_i[1];
          gap_to_crc = cyc - last_crc_edge;
        end
        mdl_crc = mdl_step(mdl_crc, s_data_i, mdl_poly, mdl_ri);
        exp_q.push_back('{data: s_data_i, last: 1'b0});
        mdl_first = s_last_i;
        if (s_last_i) begin
          exp_q.push_back('{data: mdl_final(mdl_crc, mdl_ro, mdl_xo), last: 1'b1});
          crc_owed++;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    m_ready_i <= rdy_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send_pkt(input logic [31:0] w[$], input bit gaps, input bit scramble);
    for (int i = 0; i < w.size(); i++) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        s_valid_i = 1'b0;
        repeat ($urandom_range(1, 3)) @(posedge clk);
        #1;
      end
      s_valid_i = 1'b1;
      s_data_i  = w[i];
      s_last_i  = (i == w.size() - 1);
      do @(negedge clk); while (!s_ready_o);
      @(posedge clk);
      #1;
      if (scramble && i == 0) begin
        poly_i    = $urandom;
        init_i    = $urandom;
        xor_out_i = $urandom;
        refl_i    = ~refl_i;
      end
    end
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || m_valid_o) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [31:0] p, input logic [31:0] i, input logic [31:0] x, input logic [1:0] r);
    poly_i = p; init_i = i; xor_out_i = x; refl_i = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG_CYC, 0);
    finish_run();
  end

  initial begin
    logic [31:0] hello[$];
    logic [31:0] polys[3];
    logic [31:0] pkt[$];
    logic [31:0] saved;
    hello = '{32'h6C6C6548, 32'h6F57206F, 32'h21646C72};
    polys = '{32'h04C11DB7, 32'h814141AB, 32'hF4ACFB13};

    repeat (3) @(negedge clk);
    // R10
    check(m_valid_o == 1'b0, "R10 reset m_valid", {31'b0, m_valid_o}, 32'd0);
    check(s_ready_o == 1'b1, "R10 reset s_ready", {31'b0, s_ready_o}, 32'd1);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R3 known value
    set_cfg(32'h04C11DB7, 32'h0, 32'h0, 2'b00);
    send_pkt(hello, 0, 0); drain();
    check(last_crc_seen == 32'h9D79D770, "R3 known crc", last_crc_seen, 32'h9D79D770);
    // R4 known value
    set_cfg(32'h04C11DB7, 32'h0, 32'h0, 2'b11);
    send_pkt(hello, 0, 0); drain();
    check(last_crc_seen == 32'h67FCDACC, "R4 known crc", last_crc_seen, 32'h67FCDACC);
    // R5 known values
    set_cfg(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11);
    send_pkt(hello, 0, 0); drain();
    check(last_crc_seen == 32'h1C291CA3, "R5 known crc refl", last_crc_seen, 32'h1C291CA3);
    set_cfg(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00);
    send_pkt(hello, 0, 0); drain();
    check(last_crc_seen == 32'h6B1A7CAE, "R5 known crc plain", last_crc_seen, 32'h6B1A7CAE);

    // R6: config scrambled after first beat
    set_cfg(32'h04C11DB7, 32'h0, 32'h0, 2'b00);
    send_pkt(hello, 0, 1); drain();
    check(last_crc_seen == 32'h9D79D770, "R6 cfg captured", last_crc_seen, 32'h9D79D770);

    // R9: back to back, consumer always ready
    rdy_rand = 0;
    set_cfg(32'h04C11DB7, 32'h0, 32'h0, 2'b00);
    send_pkt(hello, 0, 0);
    set_cfg(32'hF4ACFB13, 32'hFFFFFFFF, 32'h0, 2'b11);
    send_pkt(hello, 0, 0);
    saved = gap_to_crc;
    drain();
    check(saved == 0, "R9 next pkt same edge", saved, 32'd0);

    // R10 single beat packet
    pkt = '{32'hDEADBEEF};
    send_pkt(pkt, 0, 0); drain();

    // sweep all modes under random backpressure and gaps (R1 R2 R4 R5 R7 R8)
    rdy_rand = 1;
    foreach (polys[p])
      for (int iv = 0; iv < 2; iv++)
        for (int fx = 0; fx < 2; fx++)
          for (int rf = 0; rf < 4; rf++) begin
            set_cfg(polys[p], iv ? 32'hFFFFFFFF : 32'h0, fx ? 32'hFFFFFFFF : 32'h0, 2'(rf));
            send_pkt(hello, 1, 0);
          end
    for (int n = 0; n < 30; n++) begin
      pkt.delete();
      for (int k = 0; k < $urandom_range(1, 6); k++) pkt.push_back($urandom);
      set_cfg($urandom, $urandom, $urandom, 2'($urandom_range(0, 3)));
      send_pkt(pkt, 1, n[0]);
    end
    drain();
    rdy_rand = 0;
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R2 all beats out", exp_q.size(), 0);
    finish_run();
  end
endmodule